// File: doc/BRIEF.md
# Calibrated double-buffered DAC channel register bank

This block is the storage and sequencing core behind the host interface of a multi-channel converter. It has 32 channels of 12 bits by default. Each channel holds two staged codes (A and B), a gain word, an offset word and the output register that drives the converter. A host write carries a channel number, a register selector and a data word. Every staged code passes through a per-channel gain and offset stage before it can reach an output register. That stage works on one result per cycle and keeps a calibrated copy of each staged code. `busy_n` stays low while results are still outstanding.

Output registers change in four ways. A falling edge on `load_n` updates all channels at once. If that edge arrives while the block is busy, the update waits until busy ends. With `auto_ld` high, a channel instead takes each new result as soon as it is computed. While `clr_n` is low, every output is forced to a programmable clear code. A channel with toggling enabled alternates between its calibrated A and B codes on successive loads, which produces a square wave.

Top module: `dac_regbank`

## Requirements
- R1: After reset `busy_n` is 1 and every output register is 0. Gain words reset to all ones and offset words to 2048, so the calibration stage then passes a staged code through unchanged. The clear code resets to 0 and toggling is off with phase 0.
- R2: A channel's calibrated value is code × (gain + 1) / 4096 (integer division) + offset − 2048, clamped to the range 0..4095.
- R3: A host write never changes an output register directly. Outside auto mode, outputs change only on a load or a clear.
- R4: Selector codes are 0 = code A, 1 = code B, 2 = gain, 3 = offset, 4 = clear code (channel field ignored), 5 = toggle enable (data bit 0). In the cycle after an accepted write with selector 0 to 3, `busy_n` is 0.
- R5: Writes to code A or code B queue one result. A gain or offset write queues both results of that channel. One queued result is retired per cycle, so `busy_n` returns to 1 at most 2 × channels cycles after the last write, and it stays 1 while no such write arrives.
- R6: A falling edge of `load_n` sampled while busy has no effect on the outputs during busy. The load is then applied in the cycle after `busy_n` returns to 1.
- R7: A falling edge of `load_n` sampled while idle updates every output register at that same clock edge.
- R8: While `clr_n` is low, every output register takes the clear code at each clock edge. This has priority over a load, and a load falling edge seen during clear is dropped. After `clr_n` rises, the outputs keep the clear code until the next load.
- R9: On each applied load, a channel with toggling enabled inverts its phase and takes its calibrated B code when the new phase is 1, or its calibrated A code when it is 0. Other channels take their calibrated A code.
- R10: With `auto_ld` high, a channel's output register takes a freshly computed result in the same cycle, provided the result belongs to the code selected by the channel's phase. `load_n` edges are ignored in this mode.
- R11: Writes with selector 6 or 7 change no state and do not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_ch | input | CW ($clog2(NCH)) | Channel number of the write |
| wr_sel | input | 3 | Register selector (see R4) |
| wr_data | input | DW | Write data |
| load_n | input | 1 | Active-low load strobe; falling edge requests an update |
| auto_ld | input | 1 | Per-channel automatic update mode |
| clr_n | input | 1 | Active-low clear to the programmable clear code |
| busy_n | output | 1 | Low while calibrated results are outstanding |
| dac_q | output | NCH*DW | Output registers, channel c at bits c*DW +: DW |

## Verification
The properties assume that `wr_en` is a single-cycle pulse aligned with its channel, selector and data. They also assume that `load_n`, `clr_n` and `auto_ld` are synchronous levels that the bench changes only between clock edges. Under that assumption, an output change can come only from a clear, an applied load or an automatic result. The deferral property can therefore require stable outputs across any busy cycle that has neither clear nor auto mode. The bench drives every input on the falling clock edge. It never toggles `auto_ld` while results are pending, so the auto-mode property checks stay well defined. It sweeps gain, offset and code over the clamping corners on every channel of a four-channel build.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_CODE_A  = 3'd0,
      SEL_CODE_B  = 3'd1,
      SEL_GAIN    = 3'd2,
      SEL_OFFSET  = 3'd3,
      SEL_CLRCODE = 3'd4,
      SEL_TOGGLE  = 3'd5
   } sel_e;

   function automatic logic queues_a(logic [SEL_W-1:0] s);
      return (s == SEL_CODE_A) || (s == SEL_GAIN) || (s == SEL_OFFSET);
   endfunction

   function automatic logic queues_b(logic [SEL_W-1:0] s);
      return (s == SEL_CODE_B) || (s == SEL_GAIN) || (s == SEL_OFFSET);
   endfunction
endpackage

// File: rtl/dac_slot_pick.sv
module dac_slot_pick #(
   parameter int N = 64,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         vld,
   output logic [W-1:0] idx
);
   always_comb begin
      vld = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/dac_cal_math.sv
module dac_cal_math #(
   parameter int DW       = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic [DW-1:0] code,
   input  logic [DW-1:0] gain,
   input  logic [DW-1:0] offs,
   output logic [DW-1:0] res
);
   localparam int PW = 2 * DW + 1;
   localparam int SUMW = DW + 3;

   logic [PW-1:0]   prod;
   logic [DW:0]     scaled;
   logic [SUMW-1:0] sum;

   always_comb begin
      prod   = PW'(code) * PW'({1'b0, gain} + (DW + 1)'(1));
      scaled = prod[PW-1:DW];
      sum    = {2'b00, scaled} + {3'b000, offs} - (SUMW'(1) << (DW - 1));
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum[SUMW-1])         res = '0;
            else if (|sum[DW+1:DW])  res = '1;
            else                     res = sum[DW-1:0];
         end
      end else begin : g_wrap
         assign res = sum[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/dac_cal_engine.sv
module dac_cal_engine #(
   parameter int DW       = 12,
   parameter int NCH      = 32,
   parameter bit SATURATE = 1'b1,
   localparam int NSLOT = 2 * NCH,
   localparam int SW    = $clog2(NSLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSLOT-1:0]   pend_set,
   input  logic [NCH*DW-1:0]  in_a,
   input  logic [NCH*DW-1:0]  in_b,
   input  logic [NCH*DW-1:0]  gain,
   input  logic [NCH*DW-1:0]  offs,
   output logic [NCH*DW-1:0]  cal_a,
   output logic [NCH*DW-1:0]  cal_b,
   output logic               pend_any,
   output logic               done_vld,
   output logic [SW-1:0]      done_slot,
   output logic [DW-1:0]      done_val
);
   logic [NSLOT-1:0] pend;
   logic [NSLOT-1:0] retire;
   logic [SW-2:0]    ch;
   logic [DW-1:0]    op_code, op_gain, op_offs;
   logic [DW-1:0]    cal_mem [NSLOT];

   dac_slot_pick #(.N(NSLOT)) u_pick (
      .req (pend),
      .vld (done_vld),
      .idx (done_slot)
   );

   always_comb begin
      ch      = done_slot[SW-1:1];
      op_code = done_slot[0] ? in_b[ch*DW +: DW] : in_a[ch*DW +: DW];
      op_gain = gain[ch*DW +: DW];
      op_offs = offs[ch*DW +: DW];
      retire  = done_vld ? (NSLOT'(1) << done_slot) : '0;
   end

   dac_cal_math #(.DW(DW), .SATURATE(SATURATE)) u_math (
      .code (op_code),
      .gain (op_gain),
      .offs (op_offs),
      .res  (done_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         for (int i = 0; i < NSLOT; i++) cal_mem[i] <= '0;
      end else begin
         pend <= (pend & ~retire) | pend_set;
         if (done_vld) cal_mem[done_slot] <= done_val;
      end
   end

   assign pend_any = |pend;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_out
         assign cal_a[c*DW +: DW] = cal_mem[2*c];
         assign cal_b[c*DW +: DW] = cal_mem[2*c+1];
      end
   endgenerate
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic load_n,
   input  logic auto_ld,
   input  logic clr_n,
   input  logic idle,
   output logic apply
);
   logic load_d;
   logic held;
   logic fall;

   always_comb begin
      fall  = load_d & ~load_n;
      apply = (fall | held) & idle & ~auto_ld & clr_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_d <= 1'b1;
         held   <= 1'b0;
      end else begin
         load_d <= load_n;
         held   <= (fall | held) & ~idle & ~auto_ld & clr_n;
      end
   end
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
   import dac_rb_pkg::*;
#(
   parameter int NCH      = 32,
   parameter int DW       = 12,
   parameter bit SATURATE = 1'b1,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CW-1:0]     wr_ch,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DW-1:0]     wr_data,
   input  logic              load_n,
   input  logic              auto_ld,
   input  logic              clr_n,
   output logic              busy_n,
   output logic [NCH*DW-1:0] dac_q
);
   localparam int NSLOT = 2 * NCH;
   localparam int SW    = $clog2(NSLOT);

   generate
      if (NCH < 2) begin : g_chk_nch
         $error("dac_regbank: NCH must be at least 2");
      end
      if (DW < 4) begin : g_chk_dw
         $error("dac_regbank: DW must be at least 4");
      end
   endgenerate

   logic [NCH*DW-1:0] in_a, in_b, gain, offs, cal_a, cal_b;
   logic [NSLOT-1:0]  pend_set;
   logic              pend_any, done_vld, ld_apply, wr_ok;
   logic [SW-1:0]     done_slot;
   logic [DW-1:0]     done_val;
   logic [DW-1:0]     clr_code;

   assign wr_ok  = wr_en && (int'(wr_ch) < NCH);
   assign busy_n = ~pend_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                clr_code <= '0;
      else if (wr_en && wr_sel == SEL_CLRCODE)   clr_code <= wr_data;
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic          hit;
         logic [DW-1:0] a_r, b_r, g_r, o_r, d_r;
         logic          tog_r, ph_r;

         assign hit = wr_ok && (int'(wr_ch) == c);
         assign pend_set[2*c]   = hit && queues_a(wr_sel);
         assign pend_set[2*c+1] = hit && queues_b(wr_sel);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_r   <= '0;
               b_r   <= '0;
               g_r   <= '1;
               o_r   <= DW'(1) << (DW - 1);
               tog_r <= 1'b0;
            end else if (hit) begin
               case (wr_sel)
                  SEL_CODE_A: a_r   <= wr_data;
                  SEL_CODE_B: b_r   <= wr_data;
                  SEL_GAIN:   g_r   <= wr_data;
                  SEL_OFFSET: o_r   <= wr_data;
                  SEL_TOGGLE: tog_r <= wr_data[0];
                  default: ;
               endcase
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_r  <= '0;
               ph_r <= 1'b0;
            end else if (!clr_n) begin
               d_r <= clr_code;
            end else if (ld_apply) begin
               if (tog_r) begin
                  ph_r <= ~ph_r;
                  d_r  <= ph_r ? cal_a[c*DW +: DW] : cal_b[c*DW +: DW];
               end else begin
                  d_r <= cal_a[c*DW +: DW];
               end
            end else if (auto_ld && done_vld && int'(done_slot[SW-1:1]) == c
                         && done_slot[0] == ph_r) begin
               d_r <= done_val;
            end
         end

         assign in_a[c*DW +: DW]  = a_r;
         assign in_b[c*DW +: DW]  = b_r;
         assign gain[c*DW +: DW]  = g_r;
         assign offs[c*DW +: DW]  = o_r;
         assign dac_q[c*DW +: DW] = d_r;
      end
   endgenerate

   dac_cal_engine #(.DW(DW), .NCH(NCH), .SATURATE(SATURATE)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_set  (pend_set),
      .in_a      (in_a),
      .in_b      (in_b),
      .gain      (gain),
      .offs      (offs),
      .cal_a     (cal_a),
      .cal_b     (cal_b),
      .pend_any  (pend_any),
      .done_vld  (done_vld),
      .done_slot (done_slot),
      .done_val  (done_val)
   );

   dac_load_ctrl u_ld (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_n  (load_n),
      .auto_ld (auto_ld),
      .clr_n   (clr_n),
      .idle    (~pend_any),
      .apply   (ld_apply)
   );
endmodule

// File: rtl/dac_rb_chk.sv
module dac_rb_chk #(
   parameter int NCH = 32,
   parameter int DW  = 12,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [CW-1:0]     wr_ch,
   input logic [2:0]        wr_sel,
   input logic              auto_ld,
   input logic              clr_n,
   input logic              busy_n,
   input logic [NCH*DW-1:0] dac_q,
   input logic [DW-1:0]     clr_code
);
   logic        queued;
   logic [15:0] busy_cnt;

   assign queued = wr_en && (wr_sel <= 3'd3) && (int'(wr_ch) < NCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  busy_cnt <= '0;
      else if (busy_n || queued)   busy_cnt <= '0;
      else                         busy_cnt <= busy_cnt + 16'd1;
   end

   // R4
   busy_low_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      queued |=> !busy_n);

   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && !queued) |=> busy_n);

   // R5
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= 16'(2 * NCH));

   // R6
   defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && clr_n && !auto_ld) |=> $stable(dac_q));

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (dac_q[DW-1:0] == $past(clr_code)));
endmodule

bind dac_regbank dac_rb_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/tb_dac_regbank.sv
module tb_dac_regbank;
   localparam int NCH = 4;
   localparam int DW  = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_ch = '0;
   logic [2:0]      wr_sel = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            load_n = 1'b1;
   logic            auto_ld = 1'b0;
   logic            clr_n = 1'b1;
   logic            busy_n;
   logic [NCH*DW-1:0] dac_q;

   int errs = 0;
   int nchk = 0;
   int cyc = 0;
   bit done = 1'b0;

   int m_a[NCH], m_b[NCH], m_g[NCH], m_o[NCH], m_tog[NCH], m_ph[NCH], m_dac[NCH];
   int m_clr;

   always #4 clk = ~clk;

   dac_regbank #(.NCH(NCH), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
      .wr_data(wr_data), .load_n(load_n), .auto_ld(auto_ld), .clr_n(clr_n),
      .busy_n(busy_n), .dac_q(dac_q)
   );

   function automatic int mcal(int code, int g, int o);
      int s;
      s = (code * (g + 1)) / 4096 + o - 2048;
      if (s < 0) s = 0;
      if (s > 4095) s = 4095;
      return s;
   endfunction

   task automatic check(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      for (int c = 0; c < NCH; c++) check(req, int'(dac_q[c*DW +: DW]), m_dac[c]);
   endtask

   task automatic wr(int ch, int sel, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 3'(sel); wr_data = DW'(data);
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         0: m_a[ch] = data;
         1: m_b[ch] = data;
         2: m_g[ch] = data;
         3: m_o[ch] = data;
         4: m_clr = data;
         5: m_tog[ch] = data & 1;
         default: ;
      endcase
      if (sel <= 3) check("R4 busy after write", int'(busy_n), 0);
   endtask

   task automatic wait_idle();
      while (!busy_n) @(negedge clk);
   endtask

   task automatic model_load();
      for (int c = 0; c < NCH; c++) begin
         if (m_tog[c] != 0) begin
            m_ph[c] = 1 - m_ph[c];
            m_dac[c] = (m_ph[c] != 0) ? mcal(m_b[c], m_g[c], m_o[c]) : mcal(m_a[c], m_g[c], m_o[c]);
         end else begin
            m_dac[c] = mcal(m_a[c], m_g[c], m_o[c]);
         end
      end
   endtask

   // R7: the load is applied at the edge that samples the falling strobe
   task automatic pulse_load(string req, bit applies);
      @(negedge clk); load_n = 1'b0;
      @(negedge clk); load_n = 1'b1;
      if (applies) model_load();
      check_all(req);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         errs++; nchk++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errs, nchk);
         $finish;
      end
   end

   initial begin
      int gains[4] = '{4095, 2047, 0, 3000};
      int offsv[4] = '{2048, 0, 4095, 1000};
      int codes[3] = '{0, 4095, 1234};
      int cnt;
      for (int c = 0; c < NCH; c++) begin
         m_a[c] = 0; m_b[c] = 0; m_g[c] = 4095; m_o[c] = 2048;
         m_tog[c] = 0; m_ph[c] = 0; m_dac[c] = 0;
      end
      m_clr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy_n reset", int'(busy_n), 1);
      check_all("R1 dac reset");

      // R3: write alone does not reach the output
      wr(0, 0, 1000);
      check_all("R3 write not visible");
      wait_idle();
      check_all("R3 idle not visible");
      pulse_load("R1 pass-through after reset", 1'b1);

      // R5 busy length: one slot, then two slots
      wr(1, 0, 10);
      cnt = 1;
      while (!busy_n) begin @(negedge clk); cnt++; end
      check("R5 busy cycles code write", cnt, 2);
      wr(1, 2, 4095);
      cnt = 1;
      while (!busy_n) begin @(negedge clk); cnt++; end
      check("R5 busy cycles gain write", cnt, 3);
      repeat (3) @(negedge clk);
      check("R5 busy stays high", int'(busy_n), 1);

      // R2 sweep over calibration corners on every channel
      for (int c = 0; c < NCH; c++)
         for (int gi = 0; gi < 4; gi++)
            for (int oi = 0; oi < 4; oi++)
               for (int ki = 0; ki < 3; ki++) begin
                  wr(c, 2, gains[gi]);
                  wr(c, 3, offsv[oi]);
                  wr(c, 0, codes[ki]);
                  wait_idle();
                  pulse_load("R2 calibrated value", 1'b1);
               end
      wr(2, 2, 4095); wr(2, 3, 2048);

      // R6 load during busy is deferred
      wait_idle();
      pulse_load("R6 settle", 1'b1);
      wr(1, 2, 2047);
      load_n = 1'b0;
      @(negedge clk); load_n = 1'b1;
      check_all("R6 no update while busy");
      @(negedge clk);
      check("R6 busy_n high", int'(busy_n), 1);
      check_all("R6 not yet applied");
      @(negedge clk);
      model_load();
      check_all("R6 applied after busy");

      // R8 clear with priority over load
      wr(0, 4, 2748);
      @(negedge clk); clr_n = 1'b0; load_n = 1'b0;
      @(negedge clk);
      for (int c = 0; c < NCH; c++) m_dac[c] = m_clr;
      check_all("R8 clear forces code");
      @(negedge clk); load_n = 1'b1;
      @(negedge clk); clr_n = 1'b1;
      repeat (2) @(negedge clk);
      check_all("R8 holds after release");
      pulse_load("R8 load restores", 1'b1);

      // R11 reserved selectors
      wr(0, 6, 5);
      check("R11 busy unaffected", int'(busy_n), 1);
      wr(3, 7, 99);
      check("R11 busy unaffected", int'(busy_n), 1);
      check_all("R11 outputs unchanged");
      pulse_load("R11 state unchanged", 1'b1);

      // R9 toggle alternation
      wr(3, 0, 100); wr(3, 1, 3000); wr(3, 5, 1);
      wait_idle();
      pulse_load("R9 toggle to B", 1'b1);
      pulse_load("R9 toggle to A", 1'b1);
      pulse_load("R9 toggle to B again", 1'b1);

      // R10 automatic mode
      @(negedge clk); auto_ld = 1'b1;
      wr(2, 0, 2222);
      wait_idle();
      m_dac[2] = mcal(m_a[2], m_g[2], m_o[2]);
      check_all("R10 auto follows result");
      wr(3, 1, 50);
      wait_idle();
      m_dac[3] = mcal(m_b[3], m_g[3], m_o[3]);
      check_all("R10 auto phase B");
      pulse_load("R10 load ignored in auto", 1'b0);
      @(negedge clk); auto_ld = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   end
endmodule